// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block is the state machine a private cache keeps for one cached copy of a memory block in a snooping, invalidate-based multiprocessor. It takes loads, stores and eviction requests from its core, remote read and write transactions snooped from the bus, and data-fill events. From these it issues its own bus transactions, asserts a data-supply strobe when it must hand its copy to the shared level, and tells the core whether the copy may be read or written.

The copy has four stable states: modified, exclusive, shared and invalid. It also has two waiting states, held between issuing a read or write request and receiving its fill. A write to an exclusive copy becomes modified with no bus traffic. A shared copy is dropped with no bus traffic. While the core holds an atomic read-modify-write lock on a modified copy, snoops are deferred. Snoops that arrive during a waiting state are deferred in the same way. A deferred snoop is applied as soon as the copy is stable and unlocked.

The bus operation and the supply strobe are combinational responses to the inputs of the current cycle. The state, and the permissions derived from it, change at the next rising clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the state is invalid (code 0), both permissions are low and no bus operation is issued.
- R2: State codes are I=0, S=1, E=2, M=3, wait-for-read-fill=4 and wait-for-write-fill=5. rd_ok is high exactly in S, E and M. wr_ok is high exactly in M.
- R3: A load in I issues bus_op 1 (read-shared) and enters state 4. A fill in state 4 enters E when fill_excl is high and S otherwise.
- R4: A store in I issues bus_op 2 (read-for-ownership) and enters state 5. A fill in state 5 enters M.
- R5: A store in S issues bus_op 3 (upgrade, no data) and enters M on the next cycle. A store in E enters M with bus_op 0.
- R6: An eviction in M issues bus_op 5 (write-back). An eviction in E issues bus_op 4 (clean release). An eviction in S enters I with bus_op 0. In every case the state goes to I. An eviction in I does nothing.
- R7: A snooped remote read in M or E raises supply_data in that cycle and moves the copy to S. In S or I it has no effect.
- R8: A snooped remote write moves any stable valid copy to I. supply_data is raised only when the copy was in M.
- R9: Snoops seen in a waiting state are recorded. The fill still completes to its normal destination. The recorded snoop is then applied in the first cycle in that stable state.
- R10: While rmw_lock is high in M, snoops and evictions are held off: supply_data stays low and the state stays M. In the first cycle with the lock low, the deferred snoop is applied. A remote write wins over a remote read.
- R11: In a stable, unlocked state a snoop (new or deferred) takes priority over the core, and that cycle's core request issues nothing. Among core requests, a store wins over a load, and a load wins over an eviction. Core requests in a waiting state, and fills outside a waiting state, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Core load to this block |
| st_req | input | 1 | Core store to this block |
| evict_req | input | 1 | Local replacement of this block |
| rmw_lock | input | 1 | Atomic read-modify-write in progress |
| snoop_rd | input | 1 | Remote read-shared transaction observed |
| snoop_wr | input | 1 | Remote read-for-ownership observed |
| fill_valid | input | 1 | Data response for the outstanding request |
| fill_excl | input | 1 | Data response grants exclusivity |
| line_state | output | 3 | Current state code (R2) |
| bus_op | output | 3 | Transaction issued this cycle, 0 = none |
| supply_data | output | 1 | Copy is driven to the shared level this cycle |
| rd_ok | output | 1 | Core may read |
| wr_ok | output | 1 | Core may write |

## Verification
The assertions take for granted that at most one core request and at most one snoop kind are active in a cycle, and that fills arrive only while a request is outstanding. The arbitration rules of R11 still define the outcome when these assumptions are broken. The random stimulus picks at most one core request and at most one snoop kind per cycle, and raises fill_valid only while the bench model is in a waiting state. The lock is held for random stretches, so deferred snoops build up behind it. Directed sequences cover the snoop-during-fill and lock-release windows.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_req,
  input  logic       st_req,
  input  logic       evict_req,
  input  logic       rmw_lock,
  input  logic       snoop_rd,
  input  logic       snoop_wr,
  input  logic       fill_valid,
  input  logic       fill_excl,
  output logic [2:0] line_state,
  output logic [2:0] bus_op,
  output logic       supply_data,
  output logic       rd_ok,
  output logic       wr_ok
);
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_M = 3'd3, ST_WRD = 3'd4, ST_WWR = 3'd5
  } st_t;

  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_RDS  = 3'd1;
  localparam logic [2:0] OP_RFO  = 3'd2;
  localparam logic [2:0] OP_UPG  = 3'd3;
  localparam logic [2:0] OP_CLR  = 3'd4;
  localparam logic [2:0] OP_WB   = 3'd5;

  st_t  st, st_nx;
  logic pend_rd, pend_wr, pend_rd_nx, pend_wr_nx;
  logic [2:0] op;
  logic sup;

  wire waiting = (st == ST_WRD) || (st == ST_WWR);
  wire locked  = (st == ST_M) && rmw_lock;
  wire defer   = waiting || locked;
  wire eff_wr  = !defer && (snoop_wr || pend_wr);
  wire eff_rd  = !defer && (snoop_rd || pend_rd) && !eff_wr;

  always_comb begin
    st_nx      = st;
    op         = OP_NONE;
    sup        = 1'b0;
    pend_rd_nx = pend_rd;
    pend_wr_nx = pend_wr;
    if (defer) begin
      pend_rd_nx = pend_rd || snoop_rd;
      pend_wr_nx = pend_wr || snoop_wr;
      if (st == ST_WRD && fill_valid) st_nx = fill_excl ? ST_E : ST_S;
      else if (st == ST_WWR && fill_valid) st_nx = ST_M;
    end else begin
      pend_rd_nx = 1'b0;
      pend_wr_nx = 1'b0;
      if (eff_wr || eff_rd) begin
        case (st)
          ST_M: begin sup = 1'b1;   st_nx = eff_wr ? ST_I : ST_S; end
          ST_E: begin sup = eff_rd; st_nx = eff_wr ? ST_I : ST_S; end
          ST_S: if (eff_wr) st_nx = ST_I;
          default: ;
        endcase
      end else begin
        case (st)
          ST_I:
            if (st_req)      begin op = OP_RFO; st_nx = ST_WWR; end
            else if (ld_req) begin op = OP_RDS; st_nx = ST_WRD; end
          ST_S:
            if (st_req)         begin op = OP_UPG; st_nx = ST_M; end
            else if (!ld_req && evict_req) st_nx = ST_I;
          ST_E:
            if (st_req)         st_nx = ST_M;
            else if (!ld_req && evict_req) begin op = OP_CLR; st_nx = ST_I; end
          ST_M:
            if (!st_req && !ld_req && evict_req) begin op = OP_WB; st_nx = ST_I; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_I;
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
    end else begin
      st      <= st_nx;
      pend_rd <= pend_rd_nx;
      pend_wr <= pend_wr_nx;
    end
  end

  assign line_state  = st;
  assign bus_op      = op;
  assign supply_data = sup;
  assign rd_ok       = (st == ST_S) || (st == ST_E) || (st == ST_M);
  assign wr_ok       = (st == ST_M);

  p_load_miss_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_RDS) |=> (line_state == 3'd4));
  p_excl_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd4 && fill_valid && fill_excl) |=> (line_state == 3'd2));
  p_store_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_RFO) |=> (line_state == 3'd5));
  p_upgrade_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_UPG) |=> (line_state == 3'd3 && wr_ok));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_WB || bus_op == OP_CLR) |=> (line_state == 3'd0 && !rd_ok));
  p_supply_from_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_data |-> (line_state == 3'd3 || line_state == 3'd2));
  p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd3 && rmw_lock) |-> (!supply_data && bus_op == OP_NONE));
  p_lock_stays_m_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd3 && rmw_lock) |=> (line_state == 3'd3));
  p_wait_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd4 || line_state == 3'd5) |-> (bus_op == OP_NONE && !supply_data));
endmodule

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/100ps
module sim_mesi_line_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_req = 0, st_req = 0, evict_req = 0, rmw_lock = 0;
  logic snoop_rd = 0, snoop_wr = 0, fill_valid = 0, fill_excl = 0;
  logic [2:0] line_state, bus_op;
  logic supply_data, rd_ok, wr_ok;
  int checks = 0, errs = 0;
  bit done = 0;
  int m_st = 0;
  bit m_pr = 0, m_pw = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl u0 (.clk(clk), .rst_n(rst_n), .ld_req(ld_req), .st_req(st_req),
    .evict_req(evict_req), .rmw_lock(rmw_lock), .snoop_rd(snoop_rd), .snoop_wr(snoop_wr),
    .fill_valid(fill_valid), .fill_excl(fill_excl), .line_state(line_state),
    .bus_op(bus_op), .supply_data(supply_data), .rd_ok(rd_ok), .wr_ok(wr_ok));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit ld, st, ev, lk, sr, sw, fv, fx, output int op, output bit sup, output int nx);
    bit dfr, ew, er;
    op = 0; sup = 0; nx = m_st;
    dfr = (m_st == 4) || (m_st == 5) || (m_st == 3 && lk);
    if (dfr) begin
      m_pr = m_pr | sr; m_pw = m_pw | sw;
      if (m_st == 4 && fv) nx = fx ? 2 : 1;
      if (m_st == 5 && fv) nx = 3;
    end else begin
      ew = sw | m_pw; er = (sr | m_pr) & !ew;
      m_pr = 0; m_pw = 0;
      if (ew || er) begin
        if (m_st == 3) begin sup = 1; nx = ew ? 0 : 1; end
        else if (m_st == 2) begin sup = er; nx = ew ? 0 : 1; end
        else if (m_st == 1 && ew) nx = 0;
      end else if (m_st == 0) begin
        if (st) begin op = 2; nx = 5; end else if (ld) begin op = 1; nx = 4; end
      end else if (m_st == 1) begin
        if (st) begin op = 3; nx = 3; end else if (!ld && ev) nx = 0;
      end else if (m_st == 2) begin
        if (st) nx = 3; else if (!ld && ev) begin op = 4; nx = 0; end
      end else if (m_st == 3) begin
        if (!st && !ld && ev) begin op = 5; nx = 0; end
      end
    end
  endtask

  task automatic step(input string tag, input bit ld, st, ev, lk, sr, sw, fv, fx);
    int op, nx; bit sup;
    @(negedge clk);
    chk({tag, " R2 state"}, line_state, m_st);
    chk({tag, " R2 rd_ok"}, rd_ok, (m_st >= 1 && m_st <= 3));
    chk({tag, " R2 wr_ok"}, wr_ok, (m_st == 3));
    ld_req = ld; st_req = st; evict_req = ev; rmw_lock = lk;
    snoop_rd = sr; snoop_wr = sw; fill_valid = fv; fill_excl = fx;
    #1;
    model(ld, st, ev, lk, sr, sw, fv, fx, op, sup, nx);
    chk({tag, " bus_op"}, bus_op, op);
    chk({tag, " supply_data"}, supply_data, sup);
    m_st = nx;
  endtask

  task automatic expect_state(input string tag, input int exp);
    @(posedge clk); #1;
    chk(tag, line_state, exp);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit lk;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", line_state, 0);
    chk("R1 rd_ok", rd_ok, 0);
    chk("R1 wr_ok", wr_ok, 0);
    chk("R1 bus_op", bus_op, 0);
    @(negedge clk); rst_n = 1'b1;

    step("R3 load miss", 1, 0, 0, 0, 0, 0, 0, 0); expect_state("R3 wait", 4);
    step("R11 load in wait", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3 excl fill", 0, 0, 0, 0, 0, 0, 1, 1); expect_state("R3 to E", 2);
    step("R5 silent E to M", 0, 1, 0, 0, 0, 0, 0, 0); expect_state("R5 in M", 3);
    step("R6 evict M", 0, 0, 1, 0, 0, 0, 0, 0); expect_state("R6 to I", 0);
    step("R6 evict I", 0, 0, 1, 0, 0, 0, 0, 0); expect_state("R6 stay I", 0);

    step("R3 load miss 2", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3 shared fill", 0, 0, 0, 0, 0, 0, 1, 0); expect_state("R3 to S", 1);
    step("R5 upgrade", 0, 1, 0, 0, 0, 0, 0, 0); expect_state("R5 upg to M", 3);
    step("R7 snoop rd in M", 0, 0, 0, 0, 1, 0, 0, 0); expect_state("R7 to S", 1);
    step("R7 snoop rd in S", 0, 0, 0, 0, 1, 0, 0, 0); expect_state("R7 stay S", 1);
    step("R8 snoop wr in S", 0, 0, 0, 0, 0, 1, 0, 0); expect_state("R8 to I", 0);
    step("R11 fill in I", 0, 0, 0, 0, 0, 0, 1, 1); expect_state("R11 fill ignored", 0);

    step("R4 store miss", 0, 1, 0, 0, 0, 0, 0, 0); expect_state("R4 wait", 5);
    step("R9 snoop in wait", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R4 fill", 0, 0, 0, 0, 0, 0, 1, 0); expect_state("R9 fill to M", 3);
    step("R9 deferred applied", 0, 0, 0, 0, 0, 0, 0, 0); expect_state("R9 to S", 1);

    step("R5 upgrade 2", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R10 locked snoop", 0, 0, 0, 1, 1, 0, 0, 0);
    step("R10 locked snoop wr", 0, 0, 1, 1, 0, 1, 0, 0); expect_state("R10 stay M", 3);
    step("R10 release", 0, 0, 0, 0, 0, 0, 0, 0); expect_state("R10 wr wins", 0);

    step("R3 load miss 3", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3 excl fill 2", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R11 snoop beats store", 0, 1, 0, 0, 1, 0, 0, 0); expect_state("R11 to S", 1);
    step("R6 silent S evict", 0, 0, 1, 0, 0, 0, 0, 0); expect_state("R6 S to I", 0);
    step("R8 snoop wr in I", 0, 0, 0, 0, 0, 1, 0, 0);
    idle("idle");

    lk = 0;
    for (int i = 0; i < 4000; i++) begin
      int c = $urandom % 8;
      int s = $urandom % 8;
      bit fv = ((m_st == 4 || m_st == 5) && ($urandom % 3 == 0));
      if ($urandom % 6 == 0) lk = !lk;
      step("random R3 R4 R5 R6 R7 R8 R9 R10 R11",
           c == 0, c == 1, c == 2, lk, s == 0, s == 1, fv, $urandom % 2 == 1);
    end
    idle("final");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule